// File: doc/BRIEF.md
# Threshold Trim Programming Command Decoder

This block listens to the event stream of a byte-level two-wire bus receiver. It picks out the write transactions that ask for one of three supply-monitor trip thresholds to be raised or to be returned to its low base value. The receiver supplies start and stop pulses, a strobe for each received byte, and a flag that marks the byte carrying the device address. A separate digital input reports whether the high programming voltage is present on the shared programming pin. A transaction is a trim command only when that voltage is already present at the start condition and the transaction has exactly the expected shape.

A trim command is committed only when its stop condition arrives. At that point the block raises a single set or reset request line for the chosen threshold, together with a busy flag. Both stay up until the programming pin is seen low, which completes the operation. While a qualified transaction is being decoded, a claim output tells the memory write path to leave the transaction alone, so that a trim command never changes ordinary memory.

Top module: `trim_prog_decoder`

## Requirements
- R1: After reset, setReq, rstReq, busy and trimClaim are all 0.
- R2: A qualified transaction made of a device-address byte A0h (addrPhase=1), then byte address 01h, 09h or 0Dh, then data byte 00h (addrPhase=0), followed by a stop, sets setReq bit 0, 1 or 2 respectively, in the cycle after the stop is sampled.
- R3: The same transaction with byte address 03h, 0Bh or 0Fh sets rstReq bit 0, 1 or 2 respectively, in the cycle after the stop is sampled.
- R4: A transaction is qualified only if progHigh is 1 in the cycle in which startEvt is sampled. A transaction whose start sees progHigh=0 raises no request, even if progHigh rises afterwards.
- R5: No request and no busy appear before the stop is sampled. A valid command whose stop sees progHigh=0 raises no request.
- R6: Once raised, a request and busy stay unchanged while progHigh stays 1. Both clear in the cycle after progHigh is sampled 0.
- R7: A wrong device address, a device byte without addrPhase, a byte address outside the six codes, a non-zero data byte, an extra byte, or a missing byte before stop each cause no request.
- R8: A start that arrives before the stop discards the partly decoded command. The new transaction is decoded from scratch.
- R9: At most one bit of {setReq, rstReq} is 1 at any time, and busy is 1 exactly when one is.
- R10: trimClaim is 1 from the cycle after a qualified A0h device byte is accepted, for as long as the bytes received so far match a trim command. It drops after the stop, after a new start, or after a mismatching byte.
- R11: A transaction that starts while busy is 1 is not qualified and changes no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startEvt | input | 1 | One-cycle start condition pulse |
| stopEvt | input | 1 | One-cycle stop condition pulse |
| byteValid | input | 1 | Strobe: rxByte holds a received byte |
| addrPhase | input | 1 | The strobed byte is the device-address byte |
| rxByte | input | 8 | Received byte |
| progHigh | input | 1 | Programming voltage present on the programming pin |
| setReq | output | 3 | One-hot request to raise threshold 1..3 |
| rstReq | output | 3 | One-hot request to reset threshold 1..3 |
| busy | output | 1 | A trim operation is waiting for the programming pin to fall |
| trimClaim | output | 1 | The current transaction is a trim command; keep it away from memory |

## Verification
Every output is a register, so each result is due exactly one clock after the input that causes it is sampled. A request and busy rise one cycle after the stop. They clear one cycle after progHigh is seen low. The claim follows each accepted or rejected byte by one cycle. The bench drives inputs on the falling edge, updates a queue-based reference model on the rising edge from the same sampled inputs, and compares all four outputs with the model on every falling edge. Each cycle of each scenario is therefore checked at its due time, and a result that comes one cycle early or late is reported.

// File: rtl/trim_prog_pkg.sv
package trim_prog_pkg;

  localparam int NUM_CH = 3;
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [7:0] DEV_ADDR  = 8'hA0;
  localparam logic [7:0] DATA_ZERO = 8'h00;

  // byte address per threshold channel; index = channel
  localparam logic [7:0] SET_CODE [NUM_CH] = '{8'h01, 8'h09, 8'h0D};
  localparam logic [7:0] RST_CODE [NUM_CH] = '{8'h03, 8'h0B, 8'h0F};

  typedef enum logic [2:0] {
    ST_IDLE,   // outside any transaction
    ST_ARMED,  // qualified start seen, waiting device byte
    ST_DEV,    // device byte matched
    ST_CODE,   // byte address matched
    ST_DATA,   // zero data byte matched, ready to commit on stop
    ST_BAD     // transaction rejected until the next start or stop
  } decState_t;

  typedef struct packed {
    logic latchCode;  // capture the decoded byte address
    logic commit;     // raise the latched request
  } ctrlStrobe_t;

  typedef struct packed {
    logic            valid;
    logic            isReset;
    logic [CH_W-1:0] ch;
  } codeInfo_t;

  function automatic codeInfo_t decodeCode(input logic [7:0] b);
    codeInfo_t info;
    info = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (b == SET_CODE[i]) begin
        info.valid   = 1'b1;
        info.isReset = 1'b0;
        info.ch      = CH_W'(i);
      end
      if (b == RST_CODE[i]) begin
        info.valid   = 1'b1;
        info.isReset = 1'b1;
        info.ch      = CH_W'(i);
      end
    end
    return info;
  endfunction

endpackage

// File: rtl/trim_prog_ctrl.sv
module trim_prog_ctrl
  import trim_prog_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startEvt,
  input  logic        stopEvt,
  input  logic        byteValid,
  input  logic        addrPhase,
  input  logic [7:0]  rxByte,
  input  logic        progHigh,
  input  logic        busy,
  output ctrlStrobe_t strobe,
  output logic        claim
);

  decState_t state, stateNext;
  codeInfo_t info;
  logic      dataByte;

  assign info     = decodeCode(rxByte);
  assign dataByte = byteValid && !addrPhase;

  always_comb begin
    stateNext = state;
    if (startEvt) begin
      stateNext = (progHigh && !busy) ? ST_ARMED : ST_BAD;
    end else if (stopEvt) begin
      stateNext = ST_IDLE;
    end else if (byteValid) begin
      unique case (state)
        ST_IDLE:  stateNext = ST_IDLE;
        ST_ARMED: stateNext = (addrPhase && rxByte == DEV_ADDR) ? ST_DEV : ST_BAD;
        ST_DEV:   stateNext = (dataByte && info.valid) ? ST_CODE : ST_BAD;
        ST_CODE:  stateNext = (dataByte && rxByte == DATA_ZERO) ? ST_DATA : ST_BAD;
        ST_DATA:  stateNext = ST_BAD;
        default:  stateNext = ST_BAD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe           = '0;
    strobe.latchCode = !startEvt && !stopEvt && state == ST_DEV && dataByte && info.valid;
    strobe.commit    = !startEvt && stopEvt && state == ST_DATA && progHigh && !busy;
  end

  assign claim = (state == ST_DEV) || (state == ST_CODE) || (state == ST_DATA);

  // R5
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> stopEvt && progHigh);

  // R4
  unqualified_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEvt && !progHigh) |=> !claim);

  // R8
  restart_drops_claim_chk: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |=> !claim);

endmodule

// File: rtl/trim_prog_dpath.sv
module trim_prog_dpath
  import trim_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [7:0]        rxByte,
  input  logic              progHigh,
  output logic [NUM_CH-1:0] setReq,
  output logic [NUM_CH-1:0] rstReq,
  output logic              busy
);

  codeInfo_t         info;
  logic [CH_W-1:0]   chSel;
  logic              kindRst;
  logic [NUM_CH-1:0] chOneHot;

  assign info = decodeCode(rxByte);

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_onehot
      assign chOneHot[g] = (chSel == CH_W'(g));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chSel   <= '0;
      kindRst <= 1'b0;
    end else if (strobe.latchCode) begin
      chSel   <= info.ch;
      kindRst <= info.isReset;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      setReq <= '0;
      rstReq <= '0;
      busy   <= 1'b0;
    end else if (strobe.commit) begin
      setReq <= kindRst ? '0 : chOneHot;
      rstReq <= kindRst ? chOneHot : '0;
      busy   <= 1'b1;
    end else if (busy && !progHigh) begin
      setReq <= '0;
      rstReq <= '0;
      busy   <= 1'b0;
    end
  end

  // R9
  single_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({setReq, rstReq}));

  // R9
  busy_matches_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == ($countones({setReq, rstReq}) == 1));

  // R6
  clear_on_pin_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !progHigh) |=> !busy);

endmodule

// File: rtl/trim_prog_decoder.sv
module trim_prog_decoder
  import trim_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startEvt,
  input  logic              stopEvt,
  input  logic              byteValid,
  input  logic              addrPhase,
  input  logic [7:0]        rxByte,
  input  logic              progHigh,
  output logic [NUM_CH-1:0] setReq,
  output logic [NUM_CH-1:0] rstReq,
  output logic              busy,
  output logic              trimClaim
);

  ctrlStrobe_t strobe;

  trim_prog_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startEvt  (startEvt),
    .stopEvt   (stopEvt),
    .byteValid (byteValid),
    .addrPhase (addrPhase),
    .rxByte    (rxByte),
    .progHigh  (progHigh),
    .busy      (busy),
    .strobe    (strobe),
    .claim     (trimClaim)
  );

  trim_prog_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rxByte   (rxByte),
    .progHigh (progHigh),
    .setReq   (setReq),
    .rstReq   (rstReq),
    .busy     (busy)
  );

  // R5
  request_after_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt));

  // R6
  request_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && progHigh) |=> $stable({setReq, rstReq}));

  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startEvt && busy) |=> !trimClaim);

endmodule

// File: tb/trim_prog_decoder_tb_top.sv
module trim_prog_decoder_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startEvt = 1'b0, stopEvt = 1'b0, byteValid = 1'b0, addrPhase = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       progHigh = 1'b0;
  logic [2:0] setReq, rstReq;
  logic       busy, trimClaim;

  int    errCnt = 0;
  int    chkCnt = 0;
  string curReq = "R1";
  bit    doneFlag = 1'b0;

  always #4 clk = ~clk;

  trim_prog_decoder dut_i (
    .clk(clk), .rstN(rstN), .startEvt(startEvt), .stopEvt(stopEvt),
    .byteValid(byteValid), .addrPhase(addrPhase), .rxByte(rxByte),
    .progHigh(progHigh), .setReq(setReq), .rstReq(rstReq),
    .busy(busy), .trimClaim(trimClaim)
  );

  // ---------------- reference model ----------------
  logic [8:0] rxQ[$];
  bit         mInTx, mQual;
  logic [2:0] mSet, mRst;
  bit         mBusy, mClaim;

  function automatic int codeIdx(input logic [7:0] b, output bit isRst);
    isRst = 0;
    case (b)
      8'h01: return 0;
      8'h09: return 1;
      8'h0D: return 2;
      8'h03: begin isRst = 1; return 0; end
      8'h0B: begin isRst = 1; return 1; end
      8'h0F: begin isRst = 1; return 2; end
      default: return -1;
    endcase
  endfunction

  function automatic bit prefixOk();
    bit r;
    if (!mInTx || !mQual || rxQ.size() < 1 || rxQ.size() > 3) return 0;
    if (rxQ[0] != {1'b1, 8'hA0}) return 0;
    if (rxQ.size() >= 2 && (rxQ[1][8] || codeIdx(rxQ[1][7:0], r) < 0)) return 0;
    if (rxQ.size() >= 3 && rxQ[2] != {1'b0, 8'h00}) return 0;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rxQ.delete();
      mInTx = 0; mQual = 0; mSet = '0; mRst = '0; mBusy = 0; mClaim = 0;
    end else begin
      bit busyBefore;
      busyBefore = mBusy;
      if (mBusy && !progHigh) begin
        mSet = '0; mRst = '0; mBusy = 0;
      end
      if (startEvt) begin
        rxQ.delete();
        mInTx = 1;
        mQual = progHigh && !busyBefore;
      end else if (stopEvt) begin
        if (prefixOk() && rxQ.size() == 3 && progHigh && !busyBefore) begin
          bit r;
          int c;
          c = codeIdx(rxQ[1][7:0], r);
          if (r) mRst[c] = 1'b1; else mSet[c] = 1'b1;
          mBusy = 1;
        end
        rxQ.delete();
        mInTx = 0;
      end else if (byteValid && mInTx) begin
        rxQ.push_back({addrPhase, rxByte});
      end
      mClaim = prefixOk();
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    chkCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!doneFlag) begin
      check(curReq, "setReq", setReq, mSet);
      check(curReq, "rstReq", rstReq, mRst);
      check(curReq, "busy", busy, mBusy);
      check(curReq, "trimClaim", trimClaim, mClaim);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseStart();
    @(negedge clk); startEvt = 1;
    @(negedge clk); startEvt = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopEvt = 1;
    @(negedge clk); stopEvt = 0;
  endtask

  task automatic sendByte(input bit ap, input logic [7:0] b);
    @(negedge clk); byteValid = 1; addrPhase = ap; rxByte = b;
    @(negedge clk); byteValid = 0; addrPhase = 0; rxByte = 8'h00;
  endtask

  task automatic setProg(input bit v);
    @(negedge clk); progHigh = v;
  endtask

  task automatic fullCmd(input logic [7:0] code, input logic [7:0] data);
    pulseStart();
    sendByte(1, 8'hA0);
    sendByte(0, code);
    sendByte(0, data);
    pulseStop();
  endtask

  task automatic finishOp();
    setProg(0);
    idle(2);
    setProg(1);
    idle(1);
  endtask

  // ---------------- scenarios ----------------
  initial begin
    logic [7:0] setCodes[3];
    logic [7:0] rstCodes[3];
    setCodes = '{8'h01, 8'h09, 8'h0D};
    rstCodes = '{8'h03, 8'h0B, 8'h0F};

    curReq = "R1";
    idle(3);
    check("R1", "setReq in reset", setReq, 0);
    check("R1", "busy in reset", busy, 0);
    rstN = 1;
    idle(2);
    check("R1", "trimClaim after reset", trimClaim, 0);
    setProg(1);

    curReq = "R2";
    for (int i = 0; i < 3; i++) begin
      fullCmd(setCodes[i], 8'h00);
      check("R2", "setReq one-hot", setReq, 1 << i);
      idle(3);
      curReq = "R6";
      check("R6", "setReq held", setReq, 1 << i);
      finishOp();
      check("R6", "busy cleared", busy, 0);
      curReq = "R2";
    end

    curReq = "R3";
    for (int i = 0; i < 3; i++) begin
      fullCmd(rstCodes[i], 8'h00);
      check("R3", "rstReq one-hot", rstReq, 1 << i);
      check("R9", "setReq idle with reset", setReq, 0);
      finishOp();
    end

    curReq = "R10";
    pulseStart();
    sendByte(1, 8'hA0);
    check("R10", "claim after device byte", trimClaim, 1);
    sendByte(0, 8'h09);
    sendByte(0, 8'h00);
    check("R5", "no busy before stop", busy, 0);
    pulseStop();
    check("R10", "claim after stop", trimClaim, 0);
    finishOp();

    curReq = "R4";
    setProg(0);
    pulseStart();
    setProg(1);
    sendByte(1, 8'hA0);
    sendByte(0, 8'h01);
    sendByte(0, 8'h00);
    pulseStop();
    check("R4", "no request unqualified", busy, 0);
    idle(2);

    curReq = "R5";
    pulseStart();
    sendByte(1, 8'hA0);
    sendByte(0, 8'h0D);
    sendByte(0, 8'h00);
    setProg(0);
    pulseStop();
    check("R5", "no request with pin low at stop", busy, 0);
    setProg(1);
    idle(2);

    curReq = "R7";
    fullCmd(8'h05, 8'h00);
    check("R7", "unknown code", busy, 0);
    fullCmd(8'h01, 8'h01);
    check("R7", "nonzero data", busy, 0);
    pulseStart(); sendByte(1, 8'hA2); sendByte(0, 8'h01); sendByte(0, 8'h00); pulseStop();
    check("R7", "wrong device", busy, 0);
    pulseStart(); sendByte(0, 8'hA0); sendByte(0, 8'h01); sendByte(0, 8'h00); pulseStop();
    check("R7", "device byte without addrPhase", busy, 0);
    pulseStart(); sendByte(1, 8'hA0); sendByte(0, 8'h01); sendByte(0, 8'h00); sendByte(0, 8'h00); pulseStop();
    check("R7", "extra byte", busy, 0);
    pulseStart(); sendByte(1, 8'hA0); sendByte(0, 8'h0B); pulseStop();
    check("R7", "missing data byte", busy, 0);
    idle(2);

    curReq = "R8";
    pulseStart(); sendByte(1, 8'hA0); sendByte(0, 8'h01);
    pulseStart();
    check("R8", "claim dropped on restart", trimClaim, 0);
    sendByte(0, 8'h00); pulseStop();
    check("R8", "partial command discarded", busy, 0);
    pulseStart(); sendByte(1, 8'hA0); sendByte(0, 8'h03);
    pulseStart(); sendByte(1, 8'hA0); sendByte(0, 8'h09); sendByte(0, 8'h00); pulseStop();
    check("R8", "fresh decode after restart", setReq, 3'b010);

    curReq = "R11";
    fullCmd(8'h0F, 8'h00);
    check("R11", "setReq unchanged while busy", setReq, 3'b010);
    check("R11", "rstReq untouched while busy", rstReq, 0);
    finishOp();
    check("R11", "nothing pending after clear", busy, 0);

    curReq = "R9";
    idle(4);
    doneFlag = 1;
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    doneFlag = 1;
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog %s actual=timeout expected=done", curReq);
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  end

endmodule